// File: doc/BRIEF.md
# Automatic RTS/CTS Handshake Controller

This block performs hardware handshaking for one serial channel. On the transmit side it watches the remote device's clear-to-send line. When that line goes high, the remote device is asking the channel to stop sending. The block then pauses the transmitter, but only at a character boundary. If the transmitter is idle, the pause takes effect at once. If a character is being shifted out, the pause waits until that character's stop bit has completed. When the line returns low, the block lets transmission continue. A rising edge on the line can also latch a status flag, provided its interrupt enable is set. The flag stays set until software clears it with a strobe.

On the receive side the block drives the request-to-send output from the receive FIFO fill level. It uses two thresholds, which gives hysteresis. RTS is dropped once the fill reaches the stop threshold. It is raised again once the fill falls to the resume threshold. Between the two thresholds RTS keeps its last value. The RTS and CTS automation each have their own enable. With automatic CTS off, transmission is always allowed. With automatic RTS off, RTS follows a software-programmed value. The serial shifter itself sits outside this block. The shifter reports two things to it: that it is idle, and that a stop bit has just completed.

Top module: `uart_hs_ctrl`

## Requirements
- R1: After reset, `tx_allow` is 1, `rts_out` is 1 and `cts_chg_flag` is 0.
- R2: While `auto_cts_en` is 0, `tx_allow` is 1 whatever `cts_in` does.
- R3: With `auto_cts_en` 1 and `tx_idle` 1, a change of `cts_in` to 1 first passes two synchronizer flops. `tx_allow` then falls on the third rising clock edge after the change.
- R4: If synchronized CTS is 1 while a character is in progress (`tx_idle` 0), `tx_allow` stays 1. It falls on the first clock edge at which `tx_stop_done` is 1, and then stays 0.
- R5: When `cts_in` returns to 0, `tx_allow` returns to 1 on the third rising clock edge after the change.
- R6: A 0-to-1 change of synchronized CTS sets `cts_chg_flag` on the same edge at which R3 would pause, but only when `cts_chg_ie` is 1. With `cts_chg_ie` at 0 the flag stays 0.
- R7: `cts_chg_flag` stays set until a clock edge at which `flag_clr` is 1, and that edge clears it. A new CTS rise in the same cycle wins over the clear.
- R8: With `auto_rts_en` 1, `rts_out` goes to 0 on the next clock edge whenever `rx_level >= stop_thr`. This check takes priority over R9.
- R9: With `auto_rts_en` 1 and `rx_level` below `stop_thr`, `rts_out` goes to 1 on the next edge whenever `rx_level <= resume_thr`.
- R10: With `auto_rts_en` 1 and `resume_thr < rx_level < stop_thr`, `rts_out` keeps its previous value.
- R11: With `auto_rts_en` 0, `rts_out` takes the value of `rts_sw` on the next clock edge, and `rx_level` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_cts_en | input | 1 | Enables CTS-driven pausing of the transmitter |
| auto_rts_en | input | 1 | Enables FIFO-driven RTS |
| cts_chg_ie | input | 1 | Interrupt enable for the CTS-change flag |
| cts_in | input | 1 | Asynchronous CTS line, 1 = stop sending |
| tx_idle | input | 1 | Transmitter has no character in progress |
| tx_stop_done | input | 1 | One-cycle pulse when a stop bit has finished |
| rx_level | input | LVL_W | Receive FIFO fill level |
| stop_thr | input | LVL_W | Fill level at which RTS is negated |
| resume_thr | input | LVL_W | Fill level at which RTS is asserted again |
| rts_sw | input | 1 | RTS value used when automatic RTS is off |
| flag_clr | input | 1 | Read-clear strobe for the status flag |
| tx_allow | output | 1 | Transmitter may start a character |
| rts_out | output | 1 | Request-to-send, 1 = asserted |
| cts_chg_flag | output | 1 | Latched CTS rising-edge status |

## Verification
The RTS path is driven by a sequence of fill levels that rises and falls across both thresholds. This separates a true hysteresis loop from a single-level comparator: the expected values differ at the levels lying between the thresholds. The CTS path is exercised twice. Once the transmitter is idle, which measures the synchronizer latency exactly. Once a character is in progress, which shows that the gate waits for the stop-bit pulse rather than acting on the line alone. Disabled-automation runs, and a CTS rise with the interrupt enable off, show that the enables really cut each path.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;

    typedef struct packed {
        logic paused;
        logic cts_prev;
        logic flag;
    } gate_st_t;

    typedef struct packed {
        logic rts;
    } rts_st_t;

endpackage

// File: rtl/uart_hs_sync.sv
module uart_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_hs_tx_gate.sv
module uart_hs_tx_gate
    import uart_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic irq_en,
    input  logic cts_s,
    input  logic tx_idle,
    input  logic tx_stop_done,
    input  logic flag_clr,
    output logic tx_allow,
    output logic cts_flag
);
    gate_st_t st_d, st_q;
    logic     cts_rise;

    always_comb begin
        st_d          = st_q;
        st_d.cts_prev = cts_s;
        cts_rise      = cts_s && !st_q.cts_prev;

        if (cts_rise && irq_en) st_d.flag = 1'b1;
        else if (flag_clr)      st_d.flag = 1'b0;

        if (!auto_en || !cts_s)            st_d.paused = 1'b0;
        else if (tx_idle || tx_stop_done)  st_d.paused = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_allow = !auto_en || !st_q.paused;
    assign cts_flag = st_q.flag;

    AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && tx_allow && !tx_idle && !tx_stop_done) |=> tx_allow); // R4
    AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_s) |=> tx_allow); // R5
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_rise && irq_en) |=> cts_flag); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_flag && !flag_clr) |=> cts_flag); // R7
endmodule

// File: rtl/uart_hs_rts.sv
module uart_hs_rts
    import uart_hs_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_val,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] stop_thr,
    input  logic [LVL_W-1:0] resume_thr,
    output logic             rts
);
    rts_st_t st_d, st_q;
    logic    at_stop, at_resume;

    always_comb begin
        at_stop   = (level >= stop_thr);
        at_resume = (level <= resume_thr);
        st_d      = st_q;
        if (!auto_en)       st_d.rts = sw_val;
        else if (at_stop)   st_d.rts = 1'b0;
        else if (at_resume) st_d.rts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.rts <= 1'b1;
        else        st_q     <= st_d;
    end

    assign rts = st_q.rts;

    AST_RTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level >= stop_thr) |=> !rts); // R8
    AST_RTS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level < stop_thr && level <= resume_thr) |=> rts); // R9
    AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level < stop_thr && level > resume_thr) |=> $stable(rts)); // R10
    AST_RTS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en) |=> (rts == $past(sw_val))); // R11
endmodule

// File: rtl/uart_hs_ctrl.sv
module uart_hs_ctrl #(
    parameter int LVL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_cts_en,
    input  logic             auto_rts_en,
    input  logic             cts_chg_ie,
    input  logic             cts_in,
    input  logic             tx_idle,
    input  logic             tx_stop_done,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] stop_thr,
    input  logic [LVL_W-1:0] resume_thr,
    input  logic             rts_sw,
    input  logic             flag_clr,
    output logic             tx_allow,
    output logic             rts_out,
    output logic             cts_chg_flag
);
    logic cts_s;

    uart_hs_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_in),
        .sync_out (cts_s)
    );

    uart_hs_tx_gate i_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_cts_en),
        .irq_en       (cts_chg_ie),
        .cts_s        (cts_s),
        .tx_idle      (tx_idle),
        .tx_stop_done (tx_stop_done),
        .flag_clr     (flag_clr),
        .tx_allow     (tx_allow),
        .cts_flag     (cts_chg_flag)
    );

    uart_hs_rts #(.LVL_W(LVL_W)) i_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_rts_en),
        .sw_val     (rts_sw),
        .level      (rx_level),
        .stop_thr   (stop_thr),
        .resume_thr (resume_thr),
        .rts        (rts_out)
    );

    AST_ALLOW_NOAUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_cts_en) |-> tx_allow); // R2
endmodule

// File: tb/test_uart_hs_ctrl.sv
module test_uart_hs_ctrl;
    localparam int LVL_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_cts_en = 1'b0, auto_rts_en = 1'b0, cts_chg_ie = 1'b0;
    logic cts_in = 1'b0, tx_idle = 1'b1, tx_stop_done = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, stop_thr = 8'd12, resume_thr = 8'd4;
    logic rts_sw = 1'b1, flag_clr = 1'b0;
    logic tx_allow, rts_out, cts_chg_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_hs_ctrl #(.LVL_W(LVL_W), .SYNC_STAGES(2)) i_uart_hs_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .cts_chg_ie(cts_chg_ie), .cts_in(cts_in), .tx_idle(tx_idle),
        .tx_stop_done(tx_stop_done), .rx_level(rx_level), .stop_thr(stop_thr),
        .resume_thr(resume_thr), .rts_sw(rts_sw), .flag_clr(flag_clr),
        .tx_allow(tx_allow), .rts_out(rts_out), .cts_chg_flag(cts_chg_flag)
    );

    // {fill level, expected rts after one edge}; stop=12, resume=4
    localparam logic [8:0] VEC [0:9] = '{
        {8'd0, 1'b1}, {8'd8, 1'b1}, {8'd12, 1'b0}, {8'd8, 1'b0}, {8'd5, 1'b0},
        {8'd4, 1'b1}, {8'd10, 1'b1}, {8'd15, 1'b0}, {8'd11, 1'b0}, {8'd3, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(2);
        chk("R1 tx_allow", tx_allow, 1'b1);
        chk("R1 rts_out", rts_out, 1'b1);
        chk("R1 flag", cts_chg_flag, 1'b0);
        rst_n = 1'b1;
        step(1);

        // R8 R9 R10: hysteresis walk
        auto_rts_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rx_level = VEC[i][8:1];
            step(1);
            chk("R8/R9/R10 rts hysteresis", rts_out, VEC[i][0]);
        end

        // R11: software value, levels ignored
        auto_rts_en = 1'b0; rts_sw = 1'b0; rx_level = 8'd0;
        step(1);
        chk("R11 rts follows sw 0", rts_out, 1'b0);
        rts_sw = 1'b1; rx_level = 8'd20;
        step(1);
        chk("R11 rts follows sw 1", rts_out, 1'b1);
        auto_rts_en = 1'b1;
        step(1);
        chk("R8 stop on re-enable", rts_out, 1'b0);

        // R2 and R6 (enable off)
        auto_cts_en = 1'b0; cts_chg_ie = 1'b0; cts_in = 1'b1;
        step(4);
        chk("R2 allow without auto", tx_allow, 1'b1);
        chk("R6 no flag when ie=0", cts_chg_flag, 1'b0);
        cts_in = 1'b0;
        step(4);

        // R3 / R6
        auto_cts_en = 1'b1; cts_chg_ie = 1'b1; tx_idle = 1'b1; cts_in = 1'b1;
        step(2);
        chk("R3 still allowed after 2 edges", tx_allow, 1'b1);
        chk("R6 flag not yet", cts_chg_flag, 1'b0);
        step(1);
        chk("R3 paused after 3 edges", tx_allow, 1'b0);
        chk("R6 flag set", cts_chg_flag, 1'b1);

        // R7
        step(3);
        chk("R7 flag holds", cts_chg_flag, 1'b1);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R7 flag cleared", cts_chg_flag, 1'b0);

        // R5
        cts_in = 1'b0;
        step(2);
        chk("R5 still paused after 2 edges", tx_allow, 1'b0);
        step(1);
        chk("R5 resumed after 3 edges", tx_allow, 1'b1);

        // R4: character in progress
        tx_idle = 1'b0; cts_in = 1'b1;
        step(3);
        chk("R4 no cut after 3 edges", tx_allow, 1'b1);
        step(3);
        chk("R4 no cut mid character", tx_allow, 1'b1);
        tx_stop_done = 1'b1;
        step(1);
        tx_stop_done = 1'b0;
        chk("R4 paused after stop bit", tx_allow, 1'b0);
        step(2);
        chk("R4 stays paused", tx_allow, 1'b0);
        cts_in = 1'b0; tx_idle = 1'b1;
        step(3);
        chk("R5 resumed", tx_allow, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule